// File: doc/BRIEF.md
# Four-Strike Watchdog Timer

This block is a watchdog peripheral with a small register interface. Each register access is a single cycle. A write uses `wr_en` with an address and 32-bit data. A read uses `rd_en`, and the registered read data appears on the next cycle. Inside the block, a reloadable tick timer divides a fixed 1 MHz enable strobe into watchdog ticks. An 8-bit countdown consumes those ticks. Each time the countdown runs out it reloads and counts one expiration. When the countdown runs out for the fourth time without a restart, the block raises its system reset output. The effective timeout is therefore four programmed periods.

Software arms or pings the watchdog with a start command. Stopping it needs a key to be written to an unlock register first. The unlock is used up by the next command write, or by a write of any other value to the unlock register. Earlier expirations can each raise a one-cycle interrupt pulse, which gives software a warning before the reset.

Top module: `quad_expiry_wdog`

## Requirements
- R1: After a synchronous reset, `irq_o` and `sys_rst_o` are low, and the config and status registers both read as zero.
- R2: The register addresses are: config at 0x00, status at 0x04, command at 0x08, unlock at 0x0C and timer control at 0x10. Config holds four fields: timer select in bits 3:0, period in bits 11:4, interrupt enable in bit 12 and reset enable in bit 15. All other config bits read as 0. Read data is valid in the cycle after `rd_en`.
- R3: Timer control holds three fields: run in bit 31, auto-reload in bit 30 and a divide value P in bits 23:0. While run is set, the timer emits one tick for every P strobes of `tick_1m_en`. If auto-reload is clear, run clears itself after the first tick.
- R4: A write to the command register with bit 0 set does four things: it loads the countdown from the config period, clears the expiration count, starts counting and serves as the keep-alive.
- R5: While counting, each tick decrements the countdown. A tick that finds the countdown at 1 reloads it from the period and adds one to the expiration count. Status bits 11:4 show the countdown and status bits 13:12 show the expiration count.
- R6: The first, second and third expirations each produce a one-cycle `irq_o` pulse, but only when the interrupt enable is set. The pulse appears in the second cycle after the strobe that produced the tick. The fourth expiration gives no pulse.
- R7: On the fourth expiration, counting stops. If reset enable is set, `sys_rst_o` rises and then stays high until the block is reset, even if a start command follows.
- R8: Command bit 1 stops the countdown only if the previous register write was the key 0xC45A, written to the low 16 bits of the unlock register. Without that key, the stop command is ignored.
- R9: The unlock is one-shot. Any command write consumes it, and so does a write of any other value to the unlock register.
- R10: A start command while counting clears the expiration count and reloads the countdown, which postpones the reset.
- R11: If reset enable is clear, the fourth expiration still stops counting, and the status then shows an expiration count of 3. `sys_rst_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1m_en | input | 1 | One-cycle strobe at 1 MHz |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Early-warning interrupt pulse |
| sys_rst_o | output | 1 | Sticky system reset request |

## Verification
Each result is due at a fixed cycle:

- A strobe on `tick_1m_en` becomes a registered timer tick after one edge.
- The countdown, status fields and `irq_o` change on the following edge.
- Read data lands one edge after `rd_en`.

The bench drives its inputs on falling edges. It checks the interrupt timing at exactly two edges after the strobe. Each strobe is followed by idle cycles before any status read, so every counter has settled. Stop and unlock behaviour is checked through the status countdown after a further tick, which shows whether counting actually continued.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int PER_W  = 8;
  localparam int SEL_W  = 4;
  localparam int EXP_W  = 2;

  localparam logic [ADDR_W-1:0] OFF_CFG  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_STAT = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_CMD  = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_KEY  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_TMR  = 5'h10;

  localparam logic [15:0] UNLOCK_KEY = 16'hC45A;

  localparam int CFG_PER_LSB = 4;
  localparam int CFG_IRQ_BIT = 12;
  localparam int CFG_RST_BIT = 15;
  localparam int STA_EXP_LSB = 12;
  localparam int CMD_GO_BIT  = 0;
  localparam int CMD_STOP_BIT = 1;
  localparam int TMR_RUN_BIT = 31;
  localparam int TMR_AUTO_BIT = 30;

  typedef struct packed {
    logic             rst_en;
    logic             irq_en;
    logic [PER_W-1:0] period;
    logic [SEL_W-1:0] sel;
  } wd_cfg_t;
endpackage

// File: rtl/wd_tick_timer.sv
module wd_tick_timer
  import wdg_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              tick_o
);
  localparam int PAD_W = DATA_W - 2 - TMR_W;

  logic             run_q, auto_q;
  logic [TMR_W-1:0] div_q, cnt_q;
  logic [TMR_W-1:0] wr_reload, cur_reload;

  always_comb begin
    wr_reload  = (wdata[TMR_W-1:0] == '0) ? '0 : wdata[TMR_W-1:0] - 1'b1;
    cur_reload = (div_q == '0) ? '0 : div_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      auto_q <= 1'b0;
      div_q  <= '0;
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (ctrl_wr) begin
        run_q  <= wdata[TMR_RUN_BIT];
        auto_q <= wdata[TMR_AUTO_BIT];
        div_q  <= wdata[TMR_W-1:0];
        cnt_q  <= wr_reload;
      end else if (run_q && strobe) begin
        if (cnt_q == '0) begin
          tick_o <= 1'b1;
          cnt_q  <= cur_reload;
          if (!auto_q) run_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign ctrl_q = {run_q, auto_q, {PAD_W{1'b0}}, div_q};

  AST_TICK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> $past(strobe)) else $error("tick without strobe"); // R3
  AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (rst)
    (tick_o && !auto_q && !$past(ctrl_wr)) |-> !run_q) else $error("one-shot kept running"); // R3
endmodule

// File: rtl/wd_countdown.sv
module wd_countdown
  import wdg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             go,
  input  logic             stop,
  input  logic [PER_W-1:0] period,
  input  logic             irq_en,
  input  logic             rst_en,
  output logic [PER_W-1:0] count_o,
  output logic [EXP_W-1:0] exp_o,
  output logic             running_o,
  output logic             irq_o,
  output logic             sys_rst_o
);
  localparam logic [EXP_W-1:0] EXP_LAST = {EXP_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o   <= '0;
      exp_o     <= '0;
      running_o <= 1'b0;
      irq_o     <= 1'b0;
      sys_rst_o <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (stop) begin
        running_o <= 1'b0;
      end else if (go) begin
        count_o   <= period;
        exp_o     <= '0;
        running_o <= 1'b1;
      end else if (running_o && tick) begin
        if (count_o <= 1) begin
          count_o <= period;
          if (exp_o == EXP_LAST) begin
            running_o <= 1'b0;
            sys_rst_o <= sys_rst_o | rst_en;
          end else begin
            exp_o <= exp_o + 1'b1;
            irq_o <= irq_en;
          end
        end else begin
          count_o <= count_o - 1'b1;
        end
      end
    end
  end

  AST_RST_HELD: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |=> sys_rst_o) else $error("reset dropped"); // R7
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (go && !stop) |=> (exp_o == '0 && running_o)) else $error("start did not clear"); // R4
  AST_EXP_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (exp_o == EXP_LAST) |=> (exp_o == EXP_LAST || exp_o == '0)) else $error("expiry wrapped"); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(irq_en)) else $error("irq while disabled"); // R6
  AST_NO_IRQ_AT_FOURTH: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_o) |-> !irq_o) else $error("irq on fourth expiry"); // R6
endmodule

// File: rtl/wd_regs.sv
module wd_regs
  import wdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PER_W-1:0]  count,
  input  logic [EXP_W-1:0]  exp_cnt,
  input  logic [DATA_W-1:0] tmr_ctrl,
  output wd_cfg_t           cfg_o,
  output logic              tmr_wr,
  output logic              go_p,
  output logic              stop_p,
  output logic              unlocked_o,
  output logic [DATA_W-1:0] rdata
);
  logic cmd_wr, key_wr;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    cmd_wr = wr_en && (addr == OFF_CMD);
    key_wr = wr_en && (addr == OFF_KEY);
    tmr_wr = wr_en && (addr == OFF_TMR);
    go_p   = cmd_wr && wdata[CMD_GO_BIT];
    stop_p = cmd_wr && wdata[CMD_STOP_BIT] && unlocked_o;
  end

  always_comb begin
    rd_mux = '0;
    unique case (addr)
      OFF_CFG: begin
        rd_mux[SEL_W-1:0]                 = cfg_o.sel;
        rd_mux[CFG_PER_LSB +: PER_W]      = cfg_o.period;
        rd_mux[CFG_IRQ_BIT]               = cfg_o.irq_en;
        rd_mux[CFG_RST_BIT]               = cfg_o.rst_en;
      end
      OFF_STAT: begin
        rd_mux[CFG_PER_LSB +: PER_W]      = count;
        rd_mux[STA_EXP_LSB +: EXP_W]      = exp_cnt;
      end
      OFF_TMR: rd_mux = tmr_ctrl;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_o      <= '0;
      unlocked_o <= 1'b0;
      rdata      <= '0;
    end else begin
      if (wr_en && addr == OFF_CFG) begin
        cfg_o.sel    <= wdata[SEL_W-1:0];
        cfg_o.period <= wdata[CFG_PER_LSB +: PER_W];
        cfg_o.irq_en <= wdata[CFG_IRQ_BIT];
        cfg_o.rst_en <= wdata[CFG_RST_BIT];
      end
      if (key_wr)      unlocked_o <= (wdata[15:0] == UNLOCK_KEY);
      else if (cmd_wr) unlocked_o <= 1'b0;
      if (rd_en) rdata <= rd_mux;
    end
  end

  AST_UNLOCK_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |=> !unlocked_o) else $error("unlock survived command"); // R9
  AST_BAD_KEY_LOCKS: assert property (@(posedge clk) disable iff (rst)
    (key_wr && wdata[15:0] != UNLOCK_KEY) |=> !unlocked_o) else $error("wrong key unlocked"); // R9
endmodule

// File: rtl/quad_expiry_wdog.sv
module quad_expiry_wdog
  import wdg_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1m_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o,
  output logic              sys_rst_o
);
  wd_cfg_t           cfg;
  logic              tmr_wr, go_p, stop_p, unlocked, tick, running;
  logic [DATA_W-1:0] tmr_ctrl;
  logic [PER_W-1:0]  count;
  logic [EXP_W-1:0]  exp_cnt;

  wd_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .count(count), .exp_cnt(exp_cnt), .tmr_ctrl(tmr_ctrl),
    .cfg_o(cfg), .tmr_wr(tmr_wr), .go_p(go_p), .stop_p(stop_p),
    .unlocked_o(unlocked), .rdata(rdata)
  );

  wd_tick_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .strobe(tick_1m_en), .ctrl_wr(tmr_wr),
    .wdata(wdata), .ctrl_q(tmr_ctrl), .tick_o(tick)
  );

  wd_countdown u_count (
    .clk(clk), .rst(rst), .tick(tick), .go(go_p), .stop(stop_p),
    .period(cfg.period), .irq_en(cfg.irq_en), .rst_en(cfg.rst_en),
    .count_o(count), .exp_o(exp_cnt), .running_o(running),
    .irq_o(irq_o), .sys_rst_o(sys_rst_o)
  );

  AST_LOCKED_STOP_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (running && !unlocked && !tick && wr_en && addr == OFF_CMD && wdata[CMD_STOP_BIT])
    |=> running) else $error("stop accepted while locked"); // R8
endmodule

// File: tb/quad_expiry_wdog_bench.sv
module quad_expiry_wdog_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_1m_en = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o, sys_rst_o;

  int checks = 0;
  int fails  = 0;
  int irq_seen = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_expiry_wdog u_quad_expiry_wdog (
    .clk(clk), .rst(rst), .tick_1m_en(tick_1m_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .sys_rst_o(sys_rst_o)
  );

  always @(negedge clk) if (!rst && irq_o) irq_seen++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0; irq_seen = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1m_en = 1'b1;
      @(negedge clk); tick_1m_en = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 sys_rst", {31'b0, sys_rst_o}, 32'h0);
    rd(5'h00, rv); check("R1 cfg", rv, 32'h0);
    rd(5'h04, rv); check("R1 status", rv, 32'h0);
  endtask

  task automatic t_config();
    do_reset();
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, rv); check("R2 cfg readback", rv, 32'h0000_9FFF);
    wr(5'h00, 32'h0000_0A5C);
    rd(5'h00, rv); check("R2 cfg fields", rv, 32'h0000_0A5C);
  endtask

  task automatic t_timer();
    do_reset();
    wr(5'h10, 32'hC000_0003);
    rd(5'h10, rv); check("R3 timer readback", rv, 32'hC000_0003);
    wr(5'h00, 32'h0000_0050);
    wr(5'h08, 32'h1);
    rd(5'h04, rv); check("R4 start loads", rv, 32'h0000_0050);
    ticks(2);
    rd(5'h04, rv); check("R3 divide not yet", rv, 32'h0000_0050);
    ticks(1);
    rd(5'h04, rv); check("R3 divide by 3", rv, 32'h0000_0040);
    wr(5'h10, 32'h8000_0001);
    ticks(1);
    rd(5'h04, rv); check("R3 one-shot tick", rv, 32'h0000_0030);
    rd(5'h10, rv); check("R3 one-shot run cleared", rv, 32'h0000_0001);
    ticks(2);
    rd(5'h04, rv); check("R3 one-shot idle", rv, 32'h0000_0030);
  endtask

  task automatic t_four_strikes();
    do_reset();
    wr(5'h10, 32'hC000_0001);
    wr(5'h00, 32'h0000_9030);
    wr(5'h08, 32'h1);
    ticks(2);
    rd(5'h04, rv); check("R5 decrement", rv, 32'h0000_0010);
    // exact irq timing on the first expiration
    @(negedge clk); tick_1m_en = 1'b1;
    @(negedge clk); tick_1m_en = 1'b0;
    check("R6 irq not early", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    check("R6 irq on time", {31'b0, irq_o}, 32'h1);
    @(negedge clk);
    check("R6 irq one cycle", {31'b0, irq_o}, 32'h0);
    rd(5'h04, rv); check("R5 first expiry", rv, 32'h0000_1030);
    ticks(6);
    rd(5'h04, rv); check("R5 third expiry", rv, 32'h0000_3030);
    check("R6 three pulses", irq_seen, 32'd3);
    check("R7 no reset yet", {31'b0, sys_rst_o}, 32'h0);
    ticks(3);
    check("R7 reset on fourth", {31'b0, sys_rst_o}, 32'h1);
    check("R6 no fourth irq", irq_seen, 32'd3);
    ticks(2);
    rd(5'h04, rv); check("R7 halted", rv, 32'h0000_3030);
    wr(5'h08, 32'h1);
    repeat (3) @(negedge clk);
    check("R7 reset sticky", {31'b0, sys_rst_o}, 32'h1);
  endtask

  task automatic t_ping_lock();
    do_reset();
    wr(5'h10, 32'hC000_0001);
    wr(5'h00, 32'h0000_0040);
    wr(5'h08, 32'h1);
    ticks(5);
    rd(5'h04, rv); check("R5 one expiry", rv, 32'h0000_1030);
    wr(5'h08, 32'h1);
    rd(5'h04, rv); check("R10 ping restarts", rv, 32'h0000_0040);
    check("R6 irq disabled", irq_seen, 32'd0);
    wr(5'h08, 32'h2); ticks(1);
    rd(5'h04, rv); check("R8 stop without key", rv, 32'h0000_0030);
    wr(5'h0C, 32'h1234); wr(5'h08, 32'h2); ticks(1);
    rd(5'h04, rv); check("R8 stop wrong key", rv, 32'h0000_0020);
    wr(5'h0C, 32'hC45A); wr(5'h08, 32'h2); ticks(1);
    rd(5'h04, rv); check("R8 stop with key", rv, 32'h0000_0020);
    wr(5'h08, 32'h1);
    wr(5'h0C, 32'hC45A); wr(5'h08, 32'h1); wr(5'h08, 32'h2); ticks(1);
    rd(5'h04, rv); check("R9 key consumed", rv, 32'h0000_0030);
    wr(5'h0C, 32'hC45A); wr(5'h0C, 32'h0001); wr(5'h08, 32'h2); ticks(1);
    rd(5'h04, rv); check("R9 bad key relocks", rv, 32'h0000_0020);
  endtask

  task automatic t_no_reset();
    do_reset();
    wr(5'h10, 32'hC000_0001);
    wr(5'h00, 32'h0000_1010);
    wr(5'h08, 32'h1);
    ticks(4);
    check("R11 no reset", {31'b0, sys_rst_o}, 32'h0);
    check("R11 three irqs", irq_seen, 32'd3);
    ticks(2);
    rd(5'h04, rv); check("R11 halted status", rv, 32'h0000_3010);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_config();
    t_timer();
    t_four_strikes();
    t_ping_lock();
    t_no_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule